// File: doc/BRIEF.md
# Single-Clock Queue with Look-Ahead Status Flags

This block is a first-in first-out buffer for data that is produced and consumed on the same clock. Words pushed on the write side are kept in a two-port storage array. They come back out on the read side in the order they arrived. A write pointer and a read pointer address the array independently, and each wraps from the last slot back to slot zero.

The full and empty indications are flip-flops, not decodes of an occupancy counter. A flag is set one edge after a lone access that would make the two pointers meet. The test is that one pointer, advanced by one, equals the other pointer. A lone access in the opposite direction clears the flag.

A write while full and a read while empty are dropped inside the block. The requester sees no effect. The read port is registered, so a word comes out one cycle after its read is accepted. An occupancy output reports how many words are held. It is derived from the two pointers and the full flag.

Top module: `sync_queue`

## Requirements
- R1: While `rst` is high at a clock edge, the queue clears. After that edge `empty` is 1, `full` is 0, `count` is 0 and `rd_data` is 0.
- R2: Words leave through `rd_data` in exactly the order in which their writes were accepted.
- R3: `rd_data` takes the oldest word at the edge that accepts a read, so it is valid in the following cycle. When no read is accepted it keeps its value.
- R4: A lone accepted write that fills the last free slot sets `full` at that edge. At that point the read pointer equals the write pointer advanced by one.
- R5: A lone accepted read of the last stored word sets `empty` at that edge. At that point the write pointer equals the read pointer advanced by one.
- R6: A lone accepted read clears `full`, and a lone accepted write clears `empty`.
- R7: A write request while `full` is 1 is dropped. No word is stored, the write pointer holds, and `count` stays at the depth.
- R8: A read request while `empty` is 1 is dropped. `count` stays 0 and `rd_data` keeps its value.
- R9: When a read and a write are both accepted in one cycle, neither flag changes and `count` is unchanged. The new word is stored, and the oldest word appears on `rd_data`.
- R10: `count` equals the number of stored words. It ranges from 0 to DEPTH, and it is 0 exactly when `empty` is 1.
- R11: Each pointer advances by one per accepted access and wraps from DEPTH-1 to 0. Order is preserved across the wrap.
- R12: When both requests arrive while full, only the read is performed. When both arrive while empty, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered oldest word, valid the cycle after an accepted read |
| full | output | 1 | Registered: no free slot |
| empty | output | 1 | Registered: no stored word |
| count | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
The hardest states to reach are the two boundaries under simultaneous requests. Both requests while full must collapse to a lone read that clears `full`. Both requests while empty must collapse to a lone write, and `rd_data` must not move. The stimulus table first fills the queue one write at a time to the top and issues a dropped write there. It then issues a double request at full, and later drains to empty and issues a dropped read and a double request at empty. The table runs the pointers past the wrap point so that order across the wrap is observed. Directed sequences then repeat a fill and drain from a wrapped start and pull reset mid-fill.

// File: rtl/sync_queue_pkg.sv
package sync_queue_pkg;

  // Kind of access accepted in a cycle: bit 1 = read, bit 0 = write
  typedef enum logic [1:0] {
    ACC_IDLE = 2'b00,
    ACC_WR   = 2'b01,
    ACC_RD   = 2'b10,
    ACC_BOTH = 2'b11
  } acc_kind_e;

endpackage

// File: rtl/queue_ptr.sv
module queue_ptr #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_inc
);

  // next slot, with explicit wrap so any depth works
  always_comb begin
    if (ptr == AW'(DEPTH - 1)) ptr_inc = '0;
    else                       ptr_inc = ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= ptr_inc;
  end

  // R11
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= AW'(DEPTH - 1));

  // R11
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));

endmodule

// File: rtl/queue_store.sv
module queue_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // write port: no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port with output-register reset
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));

endmodule

// File: rtl/queue_flags.sv
module queue_flags
  import sync_queue_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  acc_kind_e     acc,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] wr_inc,
  input  logic [AW-1:0] rd_ptr,
  input  logic [AW-1:0] rd_inc,
  output logic          full,
  output logic          empty
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      unique case (acc)
        ACC_WR: begin
          empty <= 1'b0;
          if (rd_ptr == wr_inc) full <= 1'b1;
        end
        ACC_RD: begin
          full <= 1'b0;
          if (wr_ptr == rd_inc) empty <= 1'b1;
        end
        default: ;  // idle or paired access: flags hold
      endcase
    end
  end

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R9
  pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
    acc == ACC_BOTH |=> $stable(full) && $stable(empty));

  // R6
  write_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
    acc == ACC_WR |=> !empty);

  // R6
  read_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
    acc == ACC_RD |=> !full);

endmodule

// File: rtl/sync_queue.sv
module sync_queue
  import sync_queue_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     count
);

  logic          wr_ok, rd_ok;
  logic [AW-1:0] wr_ptr, wr_inc, rd_ptr, rd_inc;
  acc_kind_e     acc;

  // blocking at the boundaries
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;
  assign acc   = acc_kind_e'({rd_ok, wr_ok});

  queue_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst(rst), .adv(wr_ok), .ptr(wr_ptr), .ptr_inc(wr_inc)
  );

  queue_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst(rst), .adv(rd_ok), .ptr(rd_ptr), .ptr_inc(rd_inc)
  );

  queue_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .we(wr_ok), .waddr(wr_ptr), .wdata(wr_data),
    .re(rd_ok), .raddr(rd_ptr), .rdata(rd_data)
  );

  queue_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .acc(acc),
    .wr_ptr(wr_ptr), .wr_inc(wr_inc),
    .rd_ptr(rd_ptr), .rd_inc(rd_inc),
    .full(full), .empty(empty)
  );

  // occupancy from pointer distance; full disambiguates equal pointers
  always_comb begin
    if (full)                  count = CW'(DEPTH);
    else if (wr_ptr >= rd_ptr) count = CW'(wr_ptr) - CW'(rd_ptr);
    else                       count = CW'(DEPTH) - CW'(rd_ptr) + CW'(wr_ptr);
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    full && wr_en && !rd_en |=> full && $stable(count));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    empty && rd_en && !wr_en |=> empty && $stable(rd_data));

  // R3
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !empty) |=> $stable(rd_data));

  // R10
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    (count <= CW'(DEPTH)) && (empty == (count == '0)));

  // R12
  full_pair_chk: assert property (@(posedge clk) disable iff (rst)
    full && wr_en && rd_en |=> !full && count == CW'(DEPTH - 1));

endmodule

// File: tb/sync_queue_test.sv
module sync_queue_test;

  localparam int DW = 8;
  localparam int DP = 4;
  localparam int CW = $clog2(DP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, empty;
  logic [CW-1:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sync_queue #(.DATA_W(DW), .DEPTH(DP)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
    .count(count)
  );

  // row: wr, rd, wdata, exp_empty, exp_full, exp_count[3:0], chk_rd, exp_rd, req[3:0]
  localparam int NROW = 16;
  localparam logic [28:0] TABLE [NROW] = '{
    {1'b1,1'b0,8'h11, 1'b0,1'b0,4'd1, 1'b0,8'h00, 4'd6 },  // R6 write clears empty
    {1'b1,1'b0,8'h22, 1'b0,1'b0,4'd2, 1'b0,8'h00, 4'd10},  // R10
    {1'b1,1'b0,8'h33, 1'b0,1'b0,4'd3, 1'b0,8'h00, 4'd10},  // R10
    {1'b1,1'b0,8'h44, 1'b0,1'b1,4'd4, 1'b0,8'h00, 4'd4 },  // R4 full on last slot
    {1'b1,1'b0,8'h55, 1'b0,1'b1,4'd4, 1'b0,8'h00, 4'd7 },  // R7 dropped write
    {1'b1,1'b1,8'h66, 1'b0,1'b0,4'd3, 1'b1,8'h11, 4'd12},  // R12 pair at full
    {1'b1,1'b1,8'h77, 1'b0,1'b0,4'd3, 1'b1,8'h22, 4'd9 },  // R9 paired access
    {1'b0,1'b1,8'h00, 1'b0,1'b0,4'd2, 1'b1,8'h33, 4'd2 },  // R2
    {1'b0,1'b1,8'h00, 1'b0,1'b0,4'd1, 1'b1,8'h44, 4'd2 },  // R2
    {1'b0,1'b1,8'h00, 1'b1,1'b0,4'd0, 1'b1,8'h77, 4'd5 },  // R5 empty on last read
    {1'b0,1'b1,8'h00, 1'b1,1'b0,4'd0, 1'b1,8'h77, 4'd8 },  // R8 dropped read
    {1'b1,1'b1,8'h88, 1'b0,1'b0,4'd1, 1'b1,8'h77, 4'd12},  // R12 pair at empty
    {1'b1,1'b0,8'h99, 1'b0,1'b0,4'd2, 1'b0,8'h00, 4'd11},  // R11 past wrap
    {1'b0,1'b1,8'h00, 1'b0,1'b0,4'd1, 1'b1,8'h88, 4'd11},  // R11
    {1'b1,1'b1,8'hAA, 1'b0,1'b0,4'd1, 1'b1,8'h99, 4'd3 },  // R3
    {1'b0,1'b1,8'h00, 1'b1,1'b0,4'd0, 1'b1,8'hAA, 4'd5 }   // R5
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic w, input logic r, input logic [DW-1:0] d);
    wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_status(input int req, input logic e, input logic f,
                              input int c);
    check(empty == e, req, "empty", 32'(empty), 32'(e));
    check(full == f, req, "full", 32'(full), 32'(f));
    check(count == CW'(c), req, "count", 32'(count), 32'(c));
  endtask

  initial begin
    // R1 reset state
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_status(1, 1'b1, 1'b0, 0);
    check(rd_data == '0, 1, "rd_data", 32'(rd_data), 0);

    for (int i = 0; i < NROW; i++) begin
      logic [28:0] row;
      row = TABLE[i];
      step(row[28], row[27], row[26:19]);
      check_status(int'(row[3:0]), row[18], row[17], int'(row[16:13]));
      if (row[12])
        check(rd_data == row[11:4], int'(row[3:0]), "rd_data",
              32'(rd_data), 32'(row[11:4]));
    end

    // R2 / R4 / R5 / R10 directed fill and drain from a wrapped start
    for (int k = 0; k < DP; k++) begin
      step(1'b1, 1'b0, DW'(8'hA0 + k));
      check_status(10, 1'b0, (k == DP - 1), k + 1);  // R10 count steps, R4 at top
    end
    for (int k = 0; k < DP; k++) begin
      step(1'b0, 1'b1, '0);
      check(rd_data == DW'(8'hA0 + k), 2, "rd_data order",
            32'(rd_data), 32'(8'hA0 + k));
      check_status(5, (k == DP - 1), 1'b0, DP - 1 - k);  // R5 at bottom
    end

    // R1 reset mid-fill
    step(1'b1, 1'b0, 8'h5A);
    step(1'b1, 1'b0, 8'h5B);
    step(1'b0, 1'b1, '0);
    rst = 1'b1;
    step(1'b0, 1'b0, '0);
    rst = 1'b0;
    check_status(1, 1'b1, 1'b0, 0);
    check(rd_data == '0, 1, "rd_data after reset", 32'(rd_data), 0);
    step(1'b0, 1'b1, '0);
    check_status(8, 1'b1, 1'b0, 0);  // R8 nothing left after reset

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule